// File: doc/BRIEF.md
# Multichannel Ramp Test Pattern Source

This block replaces converter samples with synthetic data while the receiver runs in test mode. Each receive channel has two 16-bit ramp counters, one for the in-phase (I) part and one for the quadrature (Q) part. Every counter starts from its own programmed value and moves by its own programmed step once per sample period. The sample period is the system clock divided by a programmable value. For example, a divider of 50 on a 200 MHz clock gives 4 Msps. Pacing depends only on this divided clock. No framing clock takes part.

The block runs on either all channels or the lower half of them. In complex mode it emits I and Q; in real mode it emits I only. Each emitted sample group is presented as one wide word with a valid strobe, and that word goes into a downstream output FIFO. Within the word, the I values of the enabled channels fill the lowest slots in ascending channel order. The Q values of the same channels follow. Any slot that is not used reads as zero. Groups are counted into packets of a programmed length, and the last group of each packet is marked.

Software writes configuration into staging registers through a simple write port and then issues start. The block checks the packet length against the limit for the selected geometry. The data rate must stay below what the downstream link can drain, and keeping it there is the job of software. When the FIFO is full at the moment a group is due, the block drops that group and records a sticky overflow. It does not stall.

Top module: `tpat_gen`

## Requirements
- R1: After reset, `busy`, `smp_valid`, `smp_eop`, `cfg_err` and `ovf_flag` are 0 and `smp_data` is 0.
- R2: With divider D (D ≥ 1) and an accepted start on clock edge t0, the first valid group appears after edge t0+D. Later groups appear every D cycles.
- R3: Slot values follow start + n·step modulo 2^16, where n is the number of sample periods since start. The counters wrap past 0xFFFF without saturating.
- R4: Mode register bit 0 selects the channel count: 1 means all NCH channels, 0 means channels 0 to NCH/2−1. Mode bit 1 selects real (1) or complex (0). Slot k occupies `smp_data[16k+15:16k]`. Slots hold the I values of the enabled channels in ascending order, then their Q values when the mode is complex, and every remaining slot is zero. `smp_words` gives the number of used slots.
- R5: A start is rejected when the divider is 0 or the packet length lies outside 64 to 8192/words (1024, 2048, 2048 and 4096 for the four geometries). A rejected start sets `cfg_err`, leaves `busy` at 0 and produces no output.
- R6: `smp_eop` is high with every emitted group whose index within its packet equals the packet length minus one. Ramp values carry on across packet boundaries.
- R7: When `fifo_full` is high on the edge a group is due, that group is not emitted and `ovf_flag` is set. The ramps still advance and pacing keeps its period. `ovf_flag` stays set until the next accepted start.
- R8: Register writes made while the block runs change nothing until the next start. Every start reloads the ramps from their start values.
- R9: After `stop`, `busy` is 0 and no further groups are emitted.
- R10: The register map is as follows. Address 0 holds the mode, 1 the divider and 2 the packet length. From address 16 upward there are four registers per channel (address 16 + 4·ch + 2·q + s), where q=1 selects Q and s=1 selects the step rather than the start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW (5) | Register address |
| cfg_wdata | input | W (16) | Register write data |
| start | input | 1 | Validate the staged setup, load it and run |
| stop | input | 1 | Halt generation |
| fifo_full | input | 1 | Downstream FIFO cannot accept data |
| smp_valid | output | 1 | Sample group write strobe |
| smp_data | output | 2·NCH·W (128) | Sample group, slot k at bits 16k upward |
| smp_words | output | CW (4) | Number of used slots in the group |
| smp_eop | output | 1 | Last group of a packet |
| busy | output | 1 | Generation running |
| cfg_err | output | 1 | Last start was rejected |
| ovf_flag | output | 1 | Sticky overflow: a group was dropped |

## Verification
The bench builds the block with its default parameters: four channels, 16-bit counters and a packet budget of 8192 words. With these values, all four packet ceilings and the values just beyond them can be tested through the table of setups. Start values placed next to 0xFFFF bring the 16-bit wrap within reach in a few periods. A 64-group packet at divider 2 lets two packet boundaries pass within a few hundred cycles.

// File: rtl/tpat_pkg.sv
package tpat_pkg;

    localparam int unsigned PKT_MIN = 64;

    typedef struct packed {
        logic real_only;
        logic all_ch;
    } mode_t;

    typedef enum logic [1:0] {
        REG_MODE = 2'd0,
        REG_DIV  = 2'd1,
        REG_PKT  = 2'd2
    } ctl_reg_e;

    function automatic int unsigned words_per_group(mode_t m, int unsigned nch);
        int unsigned chans;
        chans = m.all_ch ? nch : nch / 2;
        return m.real_only ? chans : 2 * chans;
    endfunction

    function automatic logic pkt_len_ok(mode_t m, logic [15:0] len,
                                        int unsigned nch, int unsigned budget);
        int unsigned lim;
        lim = budget / words_per_group(m, nch);
        return (32'(len) >= PKT_MIN) && (32'(len) <= lim);
    endfunction

endpackage

// File: rtl/tpat_pacer.sv
module tpat_pacer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         reload,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] cnt;

    assign tick = run && !reload && (cnt == div - W'(1));

    always_ff @(posedge clk) begin
        if (rst || reload || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/tpat_ramp.sv
module tpat_ramp #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] init_v,
    input  logic [W-1:0] incr_v,
    output logic [W-1:0] val
);
    logic [W-1:0] inc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            val   <= '0;
            inc_q <= '0;
        end else if (load) begin
            val   <= init_v;
            inc_q <= incr_v;
        end else if (step) begin
            val <= val + inc_q;
        end
    end
endmodule

// File: rtl/tpat_slots.sv
module tpat_slots
    import tpat_pkg::*;
#(
    parameter int NCH = 4,
    parameter int W   = 16,
    localparam int SL = 2 * NCH,
    localparam int CW = $clog2(SL + 1)
) (
    input  mode_t           mode,
    input  logic [SL*W-1:0] vals,
    output logic [SL*W-1:0] bus,
    output logic [CW-1:0]   words
);
    int unsigned na;

    always_comb begin
        na    = mode.all_ch ? NCH : NCH / 2;
        words = CW'(words_per_group(mode, NCH));
        bus   = '0;
        for (int k = 0; k < SL; k++) begin
            if (k < int'(na)) begin
                bus[k*W +: W] = vals[(k*2)*W +: W];
            end else if (!mode.real_only && (k < int'(2 * na))) begin
                bus[k*W +: W] = vals[((k - int'(na))*2 + 1)*W +: W];
            end
        end
    end
endmodule

// File: rtl/tpat_gen.sv
module tpat_gen
    import tpat_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int W      = 16,
    parameter int BUDGET = 8192,
    localparam int CHW   = $clog2(NCH),
    localparam int AW    = CHW + 3,
    localparam int SL    = 2 * NCH,
    localparam int CW    = $clog2(SL + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic [AW-1:0]   cfg_addr,
    input  logic [W-1:0]    cfg_wdata,
    input  logic            start,
    input  logic            stop,
    input  logic            fifo_full,
    output logic            smp_valid,
    output logic [SL*W-1:0] smp_data,
    output logic [CW-1:0]   smp_words,
    output logic            smp_eop,
    output logic            busy,
    output logic            cfg_err,
    output logic            ovf_flag
);
    mode_t        mode_s, mode_a;
    logic [W-1:0] div_s, div_a, pkt_s, pkt_a, pc;
    logic [W-1:0] st_s  [NCH][2];
    logic [W-1:0] inc_s [NCH][2];
    logic         run_q, cfg_ok, go_ok, tick, emit;
    logic [SL*W-1:0] vals, bus;
    logic [CW-1:0]   words;
    logic [CHW-1:0]  wch;

    assign wch = cfg_addr[AW-2:2];

    // staging registers, copied into the active set only on an accepted start
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_s <= '0;
            div_s  <= '0;
            pkt_s  <= '0;
            for (int c = 0; c < NCH; c++) begin
                for (int p = 0; p < 2; p++) begin
                    st_s[c][p]  <= '0;
                    inc_s[c][p] <= '0;
                end
            end
        end else if (cfg_we) begin
            if (cfg_addr[AW-1]) begin
                if (cfg_addr[0]) inc_s[wch][cfg_addr[1]] <= cfg_wdata;
                else             st_s[wch][cfg_addr[1]]  <= cfg_wdata;
            end else begin
                case (ctl_reg_e'(cfg_addr[1:0]))
                    REG_MODE: mode_s <= mode_t'(cfg_wdata[1:0]);
                    REG_DIV:  div_s  <= cfg_wdata;
                    REG_PKT:  pkt_s  <= cfg_wdata;
                    default:  ;
                endcase
            end
        end
    end

    assign cfg_ok = (div_s != '0) && pkt_len_ok(mode_s, pkt_s, NCH, BUDGET);
    assign go_ok  = start && cfg_ok;
    assign emit   = tick && !fifo_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 1'b0;
            cfg_err  <= 1'b0;
            ovf_flag <= 1'b0;
            mode_a   <= '0;
            div_a    <= W'(1);
            pkt_a    <= W'(PKT_MIN);
            pc       <= '0;
        end else begin
            if (tick && fifo_full) ovf_flag <= 1'b1;
            if (emit) pc <= (pc == pkt_a - W'(1)) ? '0 : pc + W'(1);
            if (start) begin
                if (cfg_ok) begin
                    run_q    <= 1'b1;
                    cfg_err  <= 1'b0;
                    ovf_flag <= 1'b0;
                    mode_a   <= mode_s;
                    div_a    <= div_s;
                    pkt_a    <= pkt_s;
                    pc       <= '0;
                end else begin
                    run_q   <= 1'b0;
                    cfg_err <= 1'b1;
                end
            end else if (stop) begin
                run_q <= 1'b0;
            end
        end
    end

    assign busy = run_q;

    tpat_pacer #(.W(W)) u_pacer (
        .clk    (clk),
        .rst    (rst),
        .run    (run_q),
        .reload (start),
        .div    (div_a),
        .tick   (tick)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        for (genvar p = 0; p < 2; p++) begin : g_cmp
            tpat_ramp #(.W(W)) u_ramp (
                .clk    (clk),
                .rst    (rst),
                .load   (go_ok),
                .step   (tick),
                .init_v (st_s[c][p]),
                .incr_v (inc_s[c][p]),
                .val    (vals[(c*2+p)*W +: W])
            );
        end
    end

    tpat_slots #(.NCH(NCH), .W(W)) u_slots (
        .mode  (mode_a),
        .vals  (vals),
        .bus   (bus),
        .words (words)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_valid <= 1'b0;
            smp_eop   <= 1'b0;
            smp_data  <= '0;
            smp_words <= '0;
        end else begin
            smp_valid <= emit;
            smp_eop   <= emit && (pc == pkt_a - W'(1));
            if (emit) begin
                smp_data  <= bus;
                smp_words <= words;
            end
        end
    end
endmodule

// File: rtl/tpat_chk.sv
module tpat_chk #(
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          fifo_full,
    input logic          busy,
    input logic          smp_valid,
    input logic          smp_eop,
    input logic [CW-1:0] smp_words,
    input logic          cfg_err,
    input logic          ovf_flag
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> !$past(fifo_full)); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !start) |=> ovf_flag); // R7
    AST_VALID_WHILE_RUN: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> $past(busy)); // R9
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !busy); // R5
    AST_EOP_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        smp_eop |-> smp_valid); // R6
    AST_WORDS_SHAPE: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> ($countones(smp_words) == 1 && smp_words >= CW'(2))); // R4
endmodule

bind tpat_gen tpat_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .fifo_full (fifo_full),
    .busy      (busy),
    .smp_valid (smp_valid),
    .smp_eop   (smp_eop),
    .smp_words (smp_words),
    .cfg_err   (cfg_err),
    .ovf_flag  (ovf_flag)
);

// File: tb/tpat_gen_bench.sv
module tpat_gen_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_we = 1'b0;
    logic [4:0]   cfg_addr = '0;
    logic [15:0]  cfg_wdata = '0;
    logic         start = 1'b0;
    logic         stop = 1'b0;
    logic         fifo_full = 1'b0;
    logic         smp_valid, smp_eop, busy, cfg_err, ovf_flag;
    logic [127:0] smp_data;
    logic [3:0]   smp_words;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int t0 = 0;
    int tlast = 0;
    logic [15:0] bst  [4][2];
    logic [15:0] binc [4][2];

    tpat_gen u_tpat_gen (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .start(start), .stop(stop), .fifo_full(fifo_full),
        .smp_valid(smp_valid), .smp_data(smp_data), .smp_words(smp_words),
        .smp_eop(smp_eop), .busy(busy), .cfg_err(cfg_err), .ovf_flag(ovf_flag)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // {mode[1:0], divider, packet length, reject expected}
    localparam logic [34:0] VEC [10] = '{
        {2'b01, 16'd5, 16'd1024, 1'b0},
        {2'b01, 16'd5, 16'd1025, 1'b1},
        {2'b11, 16'd3, 16'd2048, 1'b0},
        {2'b00, 16'd4, 16'd2049, 1'b1},
        {2'b00, 16'd6, 16'd2048, 1'b0},
        {2'b10, 16'd4, 16'd4096, 1'b0},
        {2'b10, 16'd4, 16'd4097, 1'b1},
        {2'b01, 16'd5, 16'd63,   1'b1},
        {2'b01, 16'd0, 16'd64,   1'b1},
        {2'b01, 16'd7, 16'd64,   1'b0}
    };

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic go();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        t0 = cyc; tlast = cyc;
    endtask

    task automatic halt();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    task automatic wait_group(output int dt);
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!smp_valid && guard < 5000);
        dt = cyc - tlast;
        tlast = cyc;
    endtask

    function automatic logic [15:0] ew(int slot, logic [1:0] mode, int n);
        int na = mode[0] ? 4 : 2;
        int c, p;
        if (slot < na) begin c = slot; p = 0; end
        else if (!mode[1] && slot < 2*na) begin c = slot - na; p = 1; end
        else return 16'h0;
        return 16'(int'(bst[c][p]) + n * int'(binc[c][p]));
    endfunction

    task automatic check_group(input logic [1:0] mode, input int n);
        int expw = (mode[0] ? 4 : 2) * (mode[1] ? 1 : 2);
        for (int s = 0; s < 8; s++)
            chk(smp_data[s*16 +: 16] == ew(s, mode, n), "R3/R4 slot value",
                smp_data[s*16 +: 16], ew(s, mode, n));
        chk(smp_words == 4'(expw), "R4 word count", smp_words, expw);
    endtask

    task automatic init_ramps();
        for (int c = 0; c < 4; c++) begin
            for (int p = 0; p < 2; p++) begin
                bst[c][p]  = 16'(16'h1000 * (c + 1) + 16'h0100 * p);
                binc[c][p] = 16'(c + 1 + 8 * p);
                wr(16 + c*4 + p*2, bst[c][p]);
                wr(16 + c*4 + p*2 + 1, binc[c][p]);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int dt, nv;
        logic [1:0] md;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !smp_valid && !smp_eop, "R1 idle outputs", {busy, smp_valid, smp_eop}, 0);
        chk(!cfg_err && !ovf_flag, "R1 flags", {cfg_err, ovf_flag}, 0);
        chk(smp_data == '0, "R1 data", smp_data[63:0], 0);

        // R10 register map used by all setups below
        init_ramps();

        // table walk: R2 pacing, R3/R4 values, R5 limits
        for (int i = 0; i < 10; i++) begin
            md = VEC[i][34:33];
            wr(0, {14'd0, md});
            wr(1, VEC[i][32:17]);
            wr(2, VEC[i][16:1]);
            go();
            chk(cfg_err == VEC[i][0], "R5 reject flag", cfg_err, VEC[i][0]);
            chk(busy == !VEC[i][0], "R5 busy", busy, !VEC[i][0]);
            if (!VEC[i][0]) begin
                for (int g = 0; g < 3; g++) begin
                    wait_group(dt);
                    chk(dt == int'(VEC[i][32:17]), "R2 period", dt, VEC[i][32:17]);
                    check_group(md, g);
                    chk(!smp_eop, "R6 no early eop", smp_eop, 0);
                end
                halt();
            end else begin
                nv = 0;
                repeat (20) begin @(negedge clk); if (smp_valid) nv++; end
                chk(nv == 0, "R5 no output after reject", nv, 0);
            end
        end

        // R3 wrap and R6 packet marker
        bst[0][0] = 16'hFFFE; binc[0][0] = 16'h0001;
        wr(16, bst[0][0]); wr(17, binc[0][0]);
        wr(0, 16'd1); wr(1, 16'd2); wr(2, 16'd64);
        go();
        for (int g = 0; g < 130; g++) begin
            wait_group(dt);
            if (g < 4 || g == 64) check_group(2'b01, g);
            chk(smp_eop == ((g % 64) == 63), "R6 eop position", smp_eop, (g % 64) == 63);
        end
        halt();

        // R7 overflow drop
        wr(1, 16'd8);
        go();
        wait_group(dt);
        check_group(2'b01, 0);
        fifo_full = 1'b1;
        nv = 0;
        repeat (8) begin @(negedge clk); if (smp_valid) nv++; end
        fifo_full = 1'b0;
        chk(nv == 0, "R7 group dropped", nv, 0);
        chk(ovf_flag, "R7 overflow set", ovf_flag, 1);
        wait_group(dt);
        chk(dt == 16, "R7 pacing kept", dt, 16);
        check_group(2'b01, 2);
        chk(ovf_flag, "R7 overflow sticky", ovf_flag, 1);
        halt();
        chk(ovf_flag, "R7 sticky after stop", ovf_flag, 1);
        go();
        chk(!ovf_flag, "R7 cleared by start", ovf_flag, 0);
        halt();

        // R8 configuration during run
        wr(1, 16'd20);
        go();
        wait_group(dt);
        check_group(2'b01, 0);
        wr(16, 16'h1234); wr(1, 16'd3); wr(0, 16'd3);
        wait_group(dt);
        chk(dt == 20, "R8 old divider kept", dt, 20);
        check_group(2'b01, 1);
        halt();
        bst[0][0] = 16'h1234;
        go();
        wait_group(dt);
        chk(dt == 3, "R8 new divider on restart", dt, 3);
        check_group(2'b11, 0);

        // R9 stop
        halt();
        nv = 0;
        repeat (30) begin @(negedge clk); if (smp_valid) nv++; end
        chk(nv == 0, "R9 no groups after stop", nv, 0);
        chk(!busy, "R9 idle after stop", busy, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule